// File: doc/BRIEF.md
# Fully Associative Read Cache Controller

The block is a small read-only cache placed between a processor-side request port and a main-memory read port. Each accepted request address is compared against the stored tag of every frame in parallel, with the entire address serving as the tag. A match returns the stored word and leaves the memory port untouched. A mismatch issues one memory read, forwards the returned word to the requester, and installs it in a frame whose tag becomes the requested address.

Frame selection on a fill prefers a frame that has never been filled, taking the lowest-numbered one. Once every frame holds data, the victim index comes from the low bits of a free-running LFSR. Three counters report how the cache is behaving: one for accepted requests, one for memory reads and one for requests served from the cache. Both ports use a valid/ready handshake. The memory side may take any number of cycles to accept a read and to answer it.

Top module: `assoc_rcache`

## Requirements
- R1: After reset, all three counters read zero, `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, and every frame is empty, so the first request to any address misses.
- R2: A request whose address equals the tag of a filled frame is a hit. It returns that frame's word on `rsp_data` without asserting `mem_req_valid`. At most one frame ever matches a given address.
- R3: A miss raises `mem_req_valid` with `mem_req_addr` equal to the requested address. The word arriving with `mem_rsp_valid` is returned on `rsp_data` and stored under that address, so a repeat request to that address hits.
- R4: While any frame is empty, a fill goes to an empty frame (the lowest-numbered one), so no stored address is lost. With four frames, four distinct addresses stay resident together.
- R5: When all frames are full, a miss replaces exactly one previously resident address, chosen by the LFSR.
- R6: `cnt_requests` increases by one for each request accepted (`req_valid` and `req_ready` both high on a clock edge).
- R7: `cnt_accesses` increases by one for each memory read accepted (`mem_req_valid` and `mem_req_ready` both high on a clock edge).
- R8: `cnt_hits` increases by one for each request answered without a memory read, in the same cycle that its `rsp_valid` appears.
- R9: `mem_req_valid` stays high with `mem_req_addr` unchanged until `mem_req_ready` is seen. The block then waits for `mem_rsp_valid` for any number of cycles. `req_ready` is low from acceptance until the response.
- R10: Each accepted request produces exactly one `rsp_valid` pulse, lasting one cycle.
- R11: Starting from reset, the address sequence 2, 8, 2, 13 gives miss, miss, hit, miss and leaves the counters at requests 4, accesses 3 and hits 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester presents an address |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | ADDR_W (8) | Requested address |
| rsp_valid | output | 1 | One-cycle pulse with the returned word |
| rsp_data | output | DATA_W (8) | Returned word |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | ADDR_W (8) | Address to read |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DATA_W (8) | Memory read data |
| cnt_requests | output | CNT_W (16) | Accepted-request count |
| cnt_accesses | output | CNT_W (16) | Memory-read count |
| cnt_hits | output | CNT_W (16) | Hit count |

## Verification
The bench builds the block with its defaults: four frames, 8-bit addresses and data, and 16-bit counters. With only four frames, a handful of requests moves the cache from empty through partially filled to full, so both the empty-first fill path and the LFSR eviction path are reached in a short run. With 8-bit words, the bench's memory can return a value computed from the address, so every response is checked. The memory's random accept and answer delays exercise the wait states between one cycle and several.

// File: rtl/arc_pkg.sv
package arc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_MREQ   = 2'd2,
    ST_MWAIT  = 2'd3
  } arc_state_e;
endpackage

// File: rtl/arc_tag_array.sv
module arc_tag_array #(
  parameter int NUM_FRAMES = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     lk_addr,
  input  logic                  fill_en,
  input  logic [IDX_W-1:0]      fill_idx,
  input  logic [ADDR_W-1:0]     fill_addr,
  input  logic [DATA_W-1:0]     fill_data,
  output logic                  hit,
  output logic [DATA_W-1:0]     hit_data,
  output logic [NUM_FRAMES-1:0] valid_vec
);
  logic [NUM_FRAMES-1:0] valid_q;
  logic [NUM_FRAMES-1:0] valid_d;
  logic [NUM_FRAMES-1:0] match;
  logic [ADDR_W-1:0]     tag_q  [NUM_FRAMES];
  logic [DATA_W-1:0]     word_q [NUM_FRAMES];

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    logic sel;
    assign sel      = fill_en && (fill_idx == IDX_W'(g));
    assign valid_d[g] = valid_q[g] | sel;
    assign match[g] = valid_q[g] && (tag_q[g] == lk_addr);

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[g]  <= fill_addr;
        word_q[g] <= fill_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_comb begin
    hit_data = '0;
    for (int i = 0; i < NUM_FRAMES; i++) begin
      if (match[i]) hit_data = hit_data | word_q[i];
    end
  end

  assign hit       = |match;
  assign valid_vec = valid_q;

  // R2: tags never duplicate, so the match vector is one-hot or empty
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R3: a filled frame is valid on the next cycle
  a_r3_fill_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(fill_idx)]);
endmodule

// File: rtl/arc_victim_sel.sv
module arc_victim_sel #(
  parameter int                NUM_FRAMES = 4,
  parameter int                IDX_W      = 2,
  parameter int                LFSR_W     = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS  = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED  = 8'h01
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FRAMES-1:0] valid_vec,
  output logic [IDX_W-1:0]      victim_idx
);
  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_d;
  logic [IDX_W-1:0]  free_idx;
  logic              any_free;

  always_comb begin
    lfsr_d = lfsr_q >> 1;
    if (lfsr_q[0]) lfsr_d = lfsr_d ^ LFSR_TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= LFSR_SEED;
    else        lfsr_q <= lfsr_d;
  end

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim_idx = any_free ? free_idx : lfsr_q[IDX_W-1:0];

  // R4: an empty frame exists, so the victim must be empty
  a_r4_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~valid_vec)) |-> !valid_vec[victim_idx]);

  // R5: the LFSR never locks up at zero
  a_r5_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/arc_stats.sv
module arc_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_req,
  input  logic             inc_acc,
  input  logic             inc_hit,
  output logic [CNT_W-1:0] cnt_req,
  output logic [CNT_W-1:0] cnt_acc,
  output logic [CNT_W-1:0] cnt_hit
);
  logic [CNT_W-1:0] req_q, acc_q, hit_q;
  logic [CNT_W-1:0] req_d, acc_d, hit_d;
  logic [CNT_W-1:0] open_txn;

  always_comb begin
    req_d = req_q + CNT_W'(1);
    acc_d = acc_q + CNT_W'(1);
    hit_d = hit_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      acc_q <= '0;
      hit_q <= '0;
    end else begin
      if (inc_req) req_q <= req_d;
      if (inc_acc) acc_q <= acc_d;
      if (inc_hit) hit_q <= hit_d;
    end
  end

  assign cnt_req  = req_q;
  assign cnt_acc  = acc_q;
  assign cnt_hit  = hit_q;
  assign open_txn = req_q - acc_q - hit_q;

  // R8: every request is either a hit or a memory read; at most one is open
  a_r8_count_balance: assert property (@(posedge clk) disable iff (!rst_n)
    open_txn <= CNT_W'(1));

  // R7: a hit and a memory read never count on the same edge
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_acc && inc_hit));
endmodule

// File: rtl/assoc_rcache.sv
module assoc_rcache #(
  parameter int NUM_FRAMES = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 16,
  parameter int LFSR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]  cnt_requests,
  output logic [CNT_W-1:0]  cnt_accesses,
  output logic [CNT_W-1:0]  cnt_hits
);
  import arc_pkg::*;

  localparam int IDX_W = $clog2(NUM_FRAMES);

  arc_state_e              state_q, state_d;
  logic [ADDR_W-1:0]       addr_q;
  logic [IDX_W-1:0]        victim_q;
  logic                    rsp_valid_q;
  logic [DATA_W-1:0]       rsp_data_q, rsp_data_d;
  logic                    addr_en, victim_en, rsp_set, fill_en;
  logic                    inc_req, inc_acc, inc_hit;
  logic                    hit;
  logic [DATA_W-1:0]       hit_data;
  logic [NUM_FRAMES-1:0]   valid_vec;
  logic [IDX_W-1:0]        victim_idx;

  arc_tag_array #(
    .NUM_FRAMES(NUM_FRAMES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n), .lk_addr(addr_q),
    .fill_en(fill_en), .fill_idx(victim_q), .fill_addr(addr_q),
    .fill_data(mem_rsp_data), .hit(hit), .hit_data(hit_data),
    .valid_vec(valid_vec)
  );

  arc_victim_sel #(
    .NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W), .LFSR_W(LFSR_W)
  ) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .victim_idx(victim_idx)
  );

  arc_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n),
    .inc_req(inc_req), .inc_acc(inc_acc), .inc_hit(inc_hit),
    .cnt_req(cnt_requests), .cnt_acc(cnt_accesses), .cnt_hit(cnt_hits)
  );

  always_comb begin
    state_d       = state_q;
    req_ready     = 1'b0;
    mem_req_valid = 1'b0;
    addr_en       = 1'b0;
    victim_en     = 1'b0;
    rsp_set       = 1'b0;
    rsp_data_d    = rsp_data_q;
    fill_en       = 1'b0;
    inc_acc       = 1'b0;
    inc_hit       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          addr_en = 1'b1;
          state_d = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          rsp_set    = 1'b1;
          rsp_data_d = hit_data;
          inc_hit    = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          victim_en = 1'b1;
          state_d   = ST_MREQ;
        end
      end
      ST_MREQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) begin
          inc_acc = 1'b1;
          state_d = ST_MWAIT;
        end
      end
      ST_MWAIT: begin
        if (mem_rsp_valid) begin
          fill_en    = 1'b1;
          rsp_set    = 1'b1;
          rsp_data_d = mem_rsp_data;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign inc_req = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_set;
    end
  end

  always_ff @(posedge clk) begin
    if (addr_en)   addr_q     <= req_addr;
    if (victim_en) victim_q   <= victim_idx;
    if (rsp_set)   rsp_data_q <= rsp_data_d;
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_data     = rsp_data_q;
  assign mem_req_addr = addr_q;

  // R9: a pending memory read holds its request and address
  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R10: a response lasts exactly one cycle
  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R2: a hit lookup is followed by a response, not a memory read
  a_r2_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOKUP && hit) |=> (rsp_valid && !mem_req_valid));
endmodule

// File: tb/assoc_rcache_tb_top.sv
module assoc_rcache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [7:0]  req_addr;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        mem_req_valid, mem_req_ready;
  logic [7:0]  mem_req_addr;
  logic        mem_rsp_valid;
  logic [7:0]  mem_rsp_data;
  logic [15:0] cnt_requests, cnt_accesses, cnt_hits;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  assoc_rcache dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .cnt_requests(cnt_requests), .cnt_accesses(cnt_accesses), .cnt_hits(cnt_hits)
  );

  function automatic logic [7:0] mem_word(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory model with random accept and answer delays
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(posedge clk); #1;
      if (rst_n && mem_req_valid) begin
        logic [7:0] a;
        repeat ($urandom_range(0, 2)) begin @(posedge clk); #1; end
        mem_req_ready = 1'b1;
        a = mem_req_addr;
        @(posedge clk); #1;
        mem_req_ready = 1'b0;
        repeat ($urandom_range(0, 3)) begin @(posedge clk); #1; end
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(a);
        @(posedge clk); #1;
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // cycle-by-cycle reference: counters, response pulse, memory hold
  int         exp_req = 0, exp_acc = 0, exp_hit = 0;
  bit         m_txn_mem = 1'b0, prev_rsp = 1'b0, prev_pend = 1'b0;
  logic [7:0] prev_maddr = '0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid && !m_txn_mem) exp_hit++;
      chk(int'(cnt_requests) == exp_req, "R6 cnt_requests", int'(cnt_requests), exp_req);
      chk(int'(cnt_accesses) == exp_acc, "R7 cnt_accesses", int'(cnt_accesses), exp_acc);
      chk(int'(cnt_hits) == exp_hit, "R8 cnt_hits", int'(cnt_hits), exp_hit);
      chk(!(rsp_valid && prev_rsp), "R10 rsp_valid pulse", int'(rsp_valid), 0);
      if (prev_pend)
        chk(mem_req_valid && mem_req_addr == prev_maddr, "R9 mem hold",
            int'(mem_req_addr), int'(prev_maddr));
      prev_pend  = mem_req_valid && !mem_req_ready;
      prev_maddr = mem_req_addr;
      prev_rsp   = rsp_valid;
      if (rsp_valid) m_txn_mem = 1'b0;
      if (req_valid && req_ready) exp_req++;
      if (mem_req_valid && mem_req_ready) begin
        exp_acc++;
        m_txn_mem = 1'b1;
      end
    end
  end

  task automatic do_req(input logic [7:0] a, output bit hit, output logic [7:0] d);
    bit seen_mem = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = a;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_req_valid && mem_req_ready) begin
        seen_mem = 1'b1;
        chk(mem_req_addr == a, "R3 mem_req_addr", int'(mem_req_addr), int'(a));
      end
      if (rsp_valid) break;
      chk(!req_ready, "R9 req_ready low while busy", int'(req_ready), 0);
    end
    d   = rsp_data;
    hit = !seen_mem;
    chk(d == mem_word(a), "R2/R3 rsp_data", int'(d), int'(mem_word(a)));
  endtask

  task automatic expect_req(input logic [7:0] a, input bit exp_hit_b, input string tag);
    bit         h;
    logic [7:0] d;
    do_req(a, h, d);
    chk(h == exp_hit_b, tag, int'(h), int'(exp_hit_b));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] probe [4];
    bit         h;
    logic [7:0] d;
    bit         found;
    logic [7:0] pool [6];
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(cnt_requests == 0 && cnt_accesses == 0 && cnt_hits == 0, "R1 counters",
        int'(cnt_requests) + int'(cnt_accesses) + int'(cnt_hits), 0);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 handshake idle",
        int'({req_ready, rsp_valid, mem_req_valid}), 4);

    // R11 sequence; first request also proves R1 empty frames
    expect_req(8'd2,  1'b0, "R1/R11 req 2 miss");
    expect_req(8'd8,  1'b0, "R11 req 8 miss");
    expect_req(8'd2,  1'b1, "R11 req 2 hit");
    expect_req(8'd13, 1'b0, "R11 req 13 miss");
    @(negedge clk);
    chk(cnt_requests == 4, "R11 requests", int'(cnt_requests), 4);
    chk(cnt_accesses == 3, "R11 accesses", int'(cnt_accesses), 3);
    chk(cnt_hits == 1, "R11 hits", int'(cnt_hits), 1);

    // R4: last empty frame fills, all four resident
    expect_req(8'd40, 1'b0, "R4 fill last free");
    expect_req(8'd2,  1'b1, "R4 resident 2");
    expect_req(8'd8,  1'b1, "R4 resident 8");
    expect_req(8'd13, 1'b1, "R4 resident 13");
    expect_req(8'd40, 1'b1, "R4 resident 40");

    // R5: full cache, one new address evicts exactly one old one
    expect_req(8'd99, 1'b0, "R5 miss when full");
    expect_req(8'd99, 1'b1, "R3 refill hits");
    probe[0] = 8'd2; probe[1] = 8'd8; probe[2] = 8'd13; probe[3] = 8'd40;
    found = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (!found) begin
        do_req(probe[i], h, d);
        if (!h) found = 1'b1;
      end
    end
    chk(found, "R5 exactly one evicted", int'(found), 1);

    // mixed traffic: data and counters checked by the reference every cycle
    pool[0] = 8'd2;  pool[1] = 8'd8;   pool[2] = 8'd13;
    pool[3] = 8'd77; pool[4] = 8'd200; pool[5] = 8'd255;
    for (int i = 0; i < 60; i++) begin
      logic [7:0] a;
      a = pool[$urandom_range(0, 5)];
      do_req(a, h, d);
      if (!h) expect_req(a, 1'b1, "R3 repeat after fill hits");
    end
    @(negedge clk);
    chk(int'(cnt_requests) == int'(cnt_accesses) + int'(cnt_hits), "R8 balance",
        int'(cnt_requests), int'(cnt_accesses) + int'(cnt_hits));

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule